// File: doc/BRIEF.md
# Programmable Memory Chip-Select Unit

This block sits between a processor's bus interface and external memories or peripherals. When a bus cycle starts, the block compares address bits 31:16 with eight programmable regions. Each region has a base, a mask and a control word. The block then drives one active-low chip select, an active-low output enable for reads, and four active-low byte-lane strobes. For regions set to internal termination, it counts the programmed wait states and raises a transfer acknowledge. For regions set to external termination, it holds the cycle open until an external acknowledge arrives.

A simple write/read port holds the region registers. Region 0 is special. It comes out of reset matching every address, so boot memory can sit anywhere. Its port size, termination and strobe mode are taken from three pins that are sampled while reset is held. The decode result is captured when a cycle starts, so register writes made during a cycle only affect later cycles.

Top module: `chip_select_unit`

## Requirements
- R1: While and after reset, `cs_n`, `oe_n` and `be_n` are all ones and `ta` is 0. Every base, mask, valid and control field reads back as zero, except region 0's control word.
- R2: Region 0's control word after reset holds the following, with `boot_pins` as sampled on the last reset clock:
  - wait count 15;
  - internal termination = `boot_pins[2]`;
  - port size = `boot_pins[1:0]` (00 = 32-bit, 01 = 8-bit, 1x = 16-bit);
  - burst 0;
  - byte-enable mode 1 unless the port size is 01.
- R3: Until a 1 is written to region 0's valid bit, region 0 matches every address. Writing that bit as 1 ends the global match for good.
- R4: An enabled region matches when `bus_addr[31:16]` equals its base on every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored, and bits 15:0 never take part. A region whose valid bit is clear does not match.
- R5: When several regions match, only the lowest-numbered one is selected. At most one `cs_n` bit is low in any cycle.
- R6: With internal termination and a wait count N (0 to 15), `ta` is high in the (N+1)-th cycle that the chip select is low and in no other cycle. The chip select is released in the cycle after that.
- R7: With external termination, the chip select stays low until `ext_ack` is sampled high, and `ta` stays 0 throughout.
- R8: `oe_n` changes only on the falling clock edge. It is low only during read cycles, from half a cycle after the chip select falls until half a cycle after it rises.
- R9: Active strobes follow the transfer size (0 = byte, 1 = word, 2 or 3 = longword), `bus_addr[1:0]` and the region's port size. `be_n[3]` carries byte offset 0.
  - 32-bit port: a byte uses lane 3 minus the offset, a word uses lanes 3:2 or 1:0 according to bit 1, and a longword uses all lanes.
  - 16-bit port: a byte uses lane 3 or 2 according to bit 0, and a word or longword uses lanes 3:2.
  - 8-bit port: only lane 3 is used.
  - All strobes are high when no chip select is low.
- R10: With byte-enable mode set, the strobes are driven on reads and writes. With it clear, they are driven on writes only and stay high on reads.
- R11: Clearing a region's valid bit during a cycle to that region does not disturb that cycle. The next cycle to that address no longer selects it.
- R12: Register access uses `reg_addr[4:2]` for the region and `reg_addr[1:0]` for the register:
  - 0: base, in data bits 31:16.
  - 1: mask, in bits 31:16, and valid, in bit 0.
  - 2: control. Bits 3:0 hold the wait count, bit 4 internal termination, bits 6:5 port size, bit 7 burst and bit 8 byte-enable mode.
  - Written fields read back unchanged through `reg_rdata`, and unused bits read as zero.
- R13: A cycle start whose address matches no enabled region asserts no chip select, no strobe, no output enable and no `ta`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_pins | input | 3 | Boot configuration levels for region 0, sampled during reset |
| bus_start | input | 1 | Start of a bus cycle; ignored while a cycle is open |
| bus_addr | input | 32 | Bus cycle address |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_size | input | 2 | Transfer size: 0 byte, 1 word, 2/3 longword |
| ext_ack | input | 1 | External termination acknowledge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Region index [4:2] and register select [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cs_n | output | 8 | Active-low chip selects |
| oe_n | output | 1 | Active-low output enable, falling-edge timed |
| be_n | output | 4 | Active-low byte-lane strobes |
| ta | output | 1 | Internal transfer acknowledge |

## Verification
The regions are first left in their boot state, so that any address selects region 0 with fifteen wait states. They are then given random bases, masks, port sizes and wait counts, and random cycles are aimed at each region with random don't-care bits. This separates correct masking from exact-compare or no-compare mistakes. Directed patterns cover the remaining cases:
- overlapping regions, which expose priority errors;
- an unmatched address, which exposes false selects;
- 16-bit and 8-bit ports with every size and offset, which expose lane slips;
- write-only strobe mode on reads;
- zero and maximum wait counts, which expose off-by-one timing;
- a valid bit cleared in the middle of an externally terminated cycle.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
package cs_pkg;

    localparam int CS_COUNT = 8;
    localparam int ADDR_W   = 32;
    localparam int CMP_W    = 16;
    localparam int CMP_LSB  = ADDR_W - CMP_W;
    localparam int WAIT_W   = 4;
    localparam int LANES    = 4;
    localparam int DATA_W   = 32;
    localparam int PIN_W    = 3;

    typedef enum logic [1:0] {
        XFER_BYTE = 2'd0,
        XFER_WORD = 2'd1,
        XFER_LONG = 2'd2,
        XFER_LALT = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        PORT_32  = 2'b00,
        PORT_8   = 2'b01,
        PORT_16  = 2'b10,
        PORT_16B = 2'b11
    } port_e;

    typedef enum logic [1:0] {
        KIND_BASE = 2'd0,
        KIND_MASK = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic              bem;
        logic              burst;
        port_e             psize;
        logic              int_term;
        logic [WAIT_W-1:0] waits;
    } cs_ctrl_t;

    localparam int CTRL_W = $bits(cs_ctrl_t);

    typedef struct packed {
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic             valid;
        cs_ctrl_t         ctrl;
    } cs_region_t;

    // Boot control word for region 0, derived from the sampled pins.
    function automatic cs_ctrl_t boot_ctrl(input logic [PIN_W-1:0] pins);
        cs_ctrl_t c;
        c.waits    = '1;
        c.int_term = pins[2];
        c.psize    = port_e'(pins[1:0]);
        c.burst    = 1'b0;
        c.bem      = (pins[1:0] != 2'b01);
        return c;
    endfunction

    // Active-high lane enables; lane LANES-1 carries byte offset 0.
    function automatic logic [LANES-1:0] lane_decode(input port_e ps, input xfer_e sz,
                                                     input logic [1:0] lo);
        int pw;
        int nb;
        int start;
        int off;
        logic [LANES-1:0] r;
        case (ps)
            PORT_32: pw = 4;
            PORT_8:  pw = 1;
            default: pw = 2;
        endcase
        case (sz)
            XFER_BYTE: nb = 1;
            XFER_WORD: nb = 2;
            default:   nb = 4;
        endcase
        if (nb > pw) nb = pw;
        start = int'(lo) & (pw - 1);
        start = start & ~(nb - 1);
        for (int l = 0; l < LANES; l++) begin
            off  = LANES - 1 - l;
            r[l] = (off >= start) && (off < start + nb);
        end
        return r;
    endfunction

endpackage

// File: rtl/cs_regfile.sv
`timescale 1ns/1ps
module cs_regfile
    import cs_pkg::*;
#(
    parameter int NUM_CS = CS_COUNT,
    parameter int IDX_W  = $clog2(NUM_CS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [PIN_W-1:0]              boot_pins,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              idx,
    input  reg_kind_e                     kind,
    input  logic [CMP_W-1:0]              wdata_hi,
    input  logic [CTRL_W-1:0]             wdata_lo,
    output logic [DATA_W-1:0]             rdata,
    output logic [NUM_CS-1:0][CMP_W-1:0]  bases_o,
    output logic [NUM_CS-1:0][CMP_W-1:0]  masks_o,
    output logic [NUM_CS-1:0]             valids_o,
    output logic [NUM_CS-1:0][WAIT_W-1:0] waits_o,
    output logic [NUM_CS-1:0]             int_o,
    output logic [NUM_CS-1:0]             bem_o,
    output port_e [NUM_CS-1:0]            psize_o,
    output logic                          global_o
);

    cs_region_t [NUM_CS-1:0] regs_q;
    logic                    global_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CS; i++) regs_q[i] <= '0;
            regs_q[0].ctrl <= boot_ctrl(boot_pins);
            global_q       <= 1'b1;
        end else if (wr_en && (int'(idx) < NUM_CS)) begin
            case (kind)
                KIND_BASE: regs_q[idx].base <= wdata_hi;
                KIND_MASK: begin
                    regs_q[idx].mask  <= wdata_hi;
                    regs_q[idx].valid <= wdata_lo[0];
                    if (idx == '0 && wdata_lo[0]) global_q <= 1'b0;
                end
                KIND_CTRL: regs_q[idx].ctrl <= cs_ctrl_t'(wdata_lo);
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (kind)
            KIND_BASE: rdata[DATA_W-1 -: CMP_W] = regs_q[idx].base;
            KIND_MASK: begin
                rdata[DATA_W-1 -: CMP_W] = regs_q[idx].mask;
                rdata[0]                 = regs_q[idx].valid;
            end
            KIND_CTRL: rdata[CTRL_W-1:0] = regs_q[idx].ctrl;
            default: ;
        endcase
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_out
        assign bases_o[i]  = regs_q[i].base;
        assign masks_o[i]  = regs_q[i].mask;
        assign valids_o[i] = regs_q[i].valid;
        assign waits_o[i]  = regs_q[i].ctrl.waits;
        assign int_o[i]    = regs_q[i].ctrl.int_term;
        assign bem_o[i]    = regs_q[i].ctrl.bem;
        assign psize_o[i]  = regs_q[i].ctrl.psize;
    end

    assign global_o = global_q;

endmodule

// File: rtl/cs_match.sv
`timescale 1ns/1ps
module cs_match
    import cs_pkg::*;
#(
    parameter int NUM_CS = CS_COUNT,
    parameter int IDX_W  = $clog2(NUM_CS)
) (
    input  logic [CMP_W-1:0]             addr_hi,
    input  logic [NUM_CS-1:0][CMP_W-1:0] bases_i,
    input  logic [NUM_CS-1:0][CMP_W-1:0] masks_i,
    input  logic [NUM_CS-1:0]            valids_i,
    input  logic                         global_i,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [NUM_CS-1:0] match;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cmp
        logic cmp_ok;
        assign cmp_ok = ((addr_hi ^ bases_i[i]) & ~masks_i[i]) == '0;
        if (i == 0) begin : g_boot
            assign match[i] = global_i || (valids_i[i] && cmp_ok);
        end else begin : g_plain
            assign match[i] = valids_i[i] && cmp_ok;
        end
    end

    // Lowest index wins: scan downward so the last hit kept is the smallest.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/cs_cycle.sv
`timescale 1ns/1ps
module cs_cycle
    import cs_pkg::*;
#(
    parameter int NUM_CS = CS_COUNT,
    parameter int IDX_W  = $clog2(NUM_CS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              rd_i,
    input  xfer_e             size_i,
    input  logic [1:0]        lo_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  hit_idx_i,
    input  logic [WAIT_W-1:0] waits_i,
    input  logic              int_i,
    input  logic              bem_i,
    input  port_e             psize_i,
    input  logic              ext_ack_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic              oe_n_o,
    output logic [LANES-1:0]  be_n_o,
    output logic              ta_o
);

    logic              active_q;
    logic [IDX_W-1:0]  sel_q;
    logic              rd_q;
    logic              int_q;
    logic              bem_q;
    logic [LANES-1:0]  lanes_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              oe_q;
    logic              done;

    assign done = int_q ? (cnt_q == '0) : ext_ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sel_q    <= '0;
            rd_q     <= 1'b0;
            int_q    <= 1'b0;
            bem_q    <= 1'b0;
            lanes_q  <= '0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            if (start_i && hit_i) begin
                active_q <= 1'b1;
                sel_q    <= hit_idx_i;
                rd_q     <= rd_i;
                int_q    <= int_i;
                bem_q    <= bem_i;
                lanes_q  <= lane_decode(psize_i, size_i, lo_i);
                cnt_q    <= waits_i;
            end
        end else if (done) begin
            active_q <= 1'b0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) oe_q <= 1'b1;
        else     oe_q <= !(active_q && rd_q);
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n_o[i] = !(active_q && (sel_q == IDX_W'(i)));
    end

    assign be_n_o = (active_q && (bem_q || !rd_q)) ? ~lanes_q : '1;
    assign ta_o   = active_q && int_q && (cnt_q == '0);
    assign oe_n_o = oe_q;

endmodule

// File: rtl/chip_select_unit.sv
`timescale 1ns/1ps
module chip_select_unit
    import cs_pkg::*;
#(
    parameter int NUM_CS = CS_COUNT,
    parameter int IDX_W  = $clog2(NUM_CS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PIN_W-1:0]    boot_pins,
    input  logic                bus_start,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_size,
    input  logic                ext_ack,
    input  logic                reg_we,
    input  logic [IDX_W+1:0]    reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_CS-1:0]   cs_n,
    output logic                oe_n,
    output logic [LANES-1:0]    be_n,
    output logic                ta
);

    logic [NUM_CS-1:0][CMP_W-1:0]  bases;
    logic [NUM_CS-1:0][CMP_W-1:0]  masks;
    logic [NUM_CS-1:0]             valids;
    logic [NUM_CS-1:0][WAIT_W-1:0] waits;
    logic [NUM_CS-1:0]             ints;
    logic [NUM_CS-1:0]             bems;
    port_e [NUM_CS-1:0]            psizes;
    logic                          global_m;
    logic                          hit;
    logic [IDX_W-1:0]              hit_idx;

    cs_regfile #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_regs (
        .clk      (clk),
        .rst      (rst),
        .boot_pins(boot_pins),
        .wr_en    (reg_we),
        .idx      (reg_addr[IDX_W+1:2]),
        .kind     (reg_kind_e'(reg_addr[1:0])),
        .wdata_hi (reg_wdata[DATA_W-1 -: CMP_W]),
        .wdata_lo (reg_wdata[CTRL_W-1:0]),
        .rdata    (reg_rdata),
        .bases_o  (bases),
        .masks_o  (masks),
        .valids_o (valids),
        .waits_o  (waits),
        .int_o    (ints),
        .bem_o    (bems),
        .psize_o  (psizes),
        .global_o (global_m)
    );

    cs_match #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_match (
        .addr_hi (bus_addr[ADDR_W-1:CMP_LSB]),
        .bases_i (bases),
        .masks_i (masks),
        .valids_i(valids),
        .global_i(global_m),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    cs_cycle #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_cycle (
        .clk      (clk),
        .rst      (rst),
        .start_i  (bus_start),
        .rd_i     (bus_rd),
        .size_i   (xfer_e'(bus_size)),
        .lo_i     (bus_addr[1:0]),
        .hit_i    (hit),
        .hit_idx_i(hit_idx),
        .waits_i  (waits[hit_idx]),
        .int_i    (ints[hit_idx]),
        .bem_i    (bems[hit_idx]),
        .psize_i  (psizes[hit_idx]),
        .ext_ack_i(ext_ack),
        .cs_n_o   (cs_n),
        .oe_n_o   (oe_n),
        .be_n_o   (be_n),
        .ta_o     (ta)
    );

endmodule

// File: rtl/cs_checker.sv
`timescale 1ns/1ps
module cs_checker #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CS-1:0] cs_n,
    input logic              oe_n,
    input logic [3:0]        be_n,
    input logic              ta,
    input logic              ext_ack
);

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst) $onehot0(~cs_n)); // R5
    AST_TA_WITH_CS: assert property (@(posedge clk) disable iff (rst) ta |-> (cs_n != '1)); // R6
    AST_TA_ENDS_CYCLE: assert property (@(posedge clk) disable iff (rst) ta |=> (cs_n == '1)); // R6
    AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
        ((cs_n != '1) && !ta && !ext_ack) |=> $stable(cs_n)); // R7
    AST_OE_IN_CYCLE: assert property (@(posedge clk) disable iff (rst) !oe_n |-> (cs_n != '1)); // R8
    AST_BE_IDLE: assert property (@(posedge clk) disable iff (rst) (cs_n == '1) |-> (be_n == '1)); // R9

endmodule

bind chip_select_unit cs_checker #(.NUM_CS(NUM_CS)) i_cs_checker (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .be_n   (be_n),
    .ta     (ta),
    .ext_ack(ext_ack)
);

// File: tb/test_chip_select_unit.sv
`timescale 1ns/1ps
module test_chip_select_unit;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  boot_pins = 3'b110;
    logic        bus_start = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic        ext_ack = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  cs_n;
    logic        oe_n;
    logic [3:0]  be_n;
    logic        ta;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] m_base [N];
    logic [15:0] m_mask [N];
    bit          m_valid[N];
    logic [8:0]  m_ctrl [N];
    bit          m_glob;

    chip_select_unit i_chip_select_unit (
        .clk(clk), .rst(rst), .boot_pins(boot_pins), .bus_start(bus_start),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_size(bus_size), .ext_ack(ext_ack),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cs_n(cs_n), .oe_n(oe_n), .be_n(be_n), .ta(ta)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_sel(input logic [31:0] a);
        for (int i = 0; i < N; i++) begin
            if (i == 0 && m_glob) return 0;
            if (m_valid[i] && (((a[31:16] ^ m_base[i]) & ~m_mask[i]) == 16'h0)) return i;
        end
        return -1;
    endfunction

    function automatic logic [3:0] exp_lanes(input logic [1:0] ps, input logic [1:0] sz, input logic [1:0] a);
        if (ps == 2'b01) return 4'b1000;
        if (ps[1]) begin
            if (sz == 2'd0) return a[0] ? 4'b0100 : 4'b1000;
            return 4'b1100;
        end
        case (sz)
            2'd0:    return 4'b1000 >> a;
            2'd1:    return a[1] ? 4'b0011 : 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(input int r, input int k);
        case (k)
            0:       return {m_base[r], 16'h0};
            1:       return {m_mask[r], 15'h0, m_valid[r]};
            2:       return {23'h0, m_ctrl[r]};
            default: return 32'h0;
        endcase
    endfunction

    // Entered and left at posedge+1.
    task automatic wr(input int r, input int k, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = {3'(r), 2'(k)}; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
        case (k)
            0: m_base[r] = d[31:16];
            1: begin m_mask[r] = d[31:16]; m_valid[r] = d[0]; if (r == 0 && d[0]) m_glob = 0; end
            2: m_ctrl[r] = d[8:0];
            default: ;
        endcase
    endtask

    task automatic rd_chk(input int r, input int k, input string req);
        reg_addr = {3'(r), 2'(k)};
        #1;
        chk(reg_rdata == exp_rd(r, k), req, reg_rdata, exp_rd(r, k));
    endtask

    task automatic set_region(input int r, input logic [15:0] b, input logic [15:0] m, input bit v,
                              input logic [8:0] c);
        wr(r, 0, {b, 16'h0});
        wr(r, 2, {23'h0, c});
        wr(r, 1, {m, 15'h0, v});
    endtask

    // Entered and left at posedge+1.
    task automatic run_cycle(input logic [31:0] a, input bit r, input logic [1:0] sz,
                             input int ext_wait, input string req);
        int idx;
        logic [8:0] c;
        logic [3:0] be_exp;
        int k;
        idx = exp_sel(a);
        bus_start = 1'b1; bus_addr = a; bus_rd = r; bus_size = sz;
        @(posedge clk); #1;
        bus_start = 1'b0;
        if (idx < 0) begin
            for (int s = 0; s < 3; s++) begin
                #2;
                chk(cs_n == 8'hFF && ta == 1'b0 && be_n == 4'hF, "R13 no select",
                    {23'h0, ta, be_n, cs_n}, 32'h0000_0FFF);
                #4;
                chk(oe_n == 1'b1, "R13 oe idle", {31'h0, oe_n}, 32'h1);
                @(posedge clk); #1;
            end
            return;
        end
        c = m_ctrl[idx];
        be_exp = (c[8] || !r) ? ~exp_lanes(c[6:5], sz, a[1:0]) : 4'hF;
        k = 0;
        while (1) begin
            #2;
            chk(cs_n == ~(8'h1 << idx), req, {24'h0, cs_n}, {24'h0, ~(8'h1 << idx)});
            chk(be_n == be_exp, "R9/R10 lanes", {28'h0, be_n}, {28'h0, be_exp});
            chk(ta == (c[4] && k == int'(c[3:0])), "R6/R7 ta", {31'h0, ta},
                {31'h0, (c[4] && k == int'(c[3:0]))});
            #4;
            chk(oe_n == !r, "R8 oe", {31'h0, oe_n}, {31'h0, !r});
            if (c[4] && k == int'(c[3:0])) begin
                @(posedge clk); #1;
                break;
            end
            if (!c[4] && k == ext_wait) begin
                ext_ack = 1'b1;
                @(posedge clk); #1;
                ext_ack = 1'b0;
                break;
            end
            if (k > 40) break;
            k++;
            @(posedge clk); #1;
        end
        #2;
        chk(cs_n == 8'hFF && ta == 1'b0, "R6/R7 release", {23'h0, ta, cs_n}, 32'h0FF);
        #4;
        chk(oe_n == 1'b1, "R8 oe release", {31'h0, oe_n}, 32'h1);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R6 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] b;
        logic [15:0] m;
        logic [8:0]  c;
        logic [31:0] a;
        int r;
        void'($urandom(32'h5EED_C5));
        for (int i = 0; i < N; i++) begin
            m_base[i] = 0; m_mask[i] = 0; m_valid[i] = 0; m_ctrl[i] = 0;
        end
        m_glob = 1;
        m_ctrl[0] = {(boot_pins[1:0] != 2'b01), 1'b0, boot_pins[1:0], boot_pins[2], 4'hF};

        repeat (4) @(posedge clk);
        #3;
        chk(cs_n == 8'hFF && oe_n && be_n == 4'hF && !ta, "R1 outputs in reset",
            {22'h0, oe_n, ta, be_n, cs_n}, {22'h0, 1'b1, 1'b0, 4'hF, 8'hFF});
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;
        chk(cs_n == 8'hFF && oe_n && be_n == 4'hF && !ta, "R1 outputs after reset",
            {22'h0, oe_n, ta, be_n, cs_n}, {22'h0, 1'b1, 1'b0, 4'hF, 8'hFF});
        for (int i = 1; i < N; i++)
            for (int k = 0; k < 4; k++) rd_chk(i, k, "R1 reset regs");
        rd_chk(0, 0, "R1 base0");
        rd_chk(0, 1, "R1 mask0");
        rd_chk(0, 2, "R2 boot ctrl");

        // Global boot match: any address selects region 0 with 15 waits, 16-bit port.
        for (int i = 0; i < 3; i++)
            run_cycle($urandom, 1'($urandom), 2'($urandom), 0, "R3 global select");
        run_cycle(32'h0000_0001, 1'b1, 2'd0, 0, "R3 global select byte");

        // Writing region 0 valid without matching ends global mode.
        set_region(0, 16'h7F00, 16'h0000, 1'b1, 9'h100);
        run_cycle(32'h1234_0000, 1'b1, 2'd2, 0, "R3 global ended");
        run_cycle(32'h7F00_0002, 1'b1, 2'd1, 0, "R3 region0 exact");

        // Random regions and random cycles.
        for (int i = 0; i < N; i++) begin
            b = 16'($urandom);
            m = 16'((32'h1 << ($urandom % 7)) - 1);
            c = {1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 4) != 0, 4'($urandom % 4)};
            set_region(i, b, m, (i == 0) || (($urandom % 4) != 0), c);
        end
        for (int i = 0; i < N; i++)
            for (int k = 0; k < 4; k++) rd_chk(i, k, "R12 readback");
        for (int t = 0; t < 80; t++) begin
            r = int'($urandom % N);
            a = {m_base[r] ^ (16'($urandom) & m_mask[r]), 16'($urandom)};
            run_cycle(a, 1'($urandom), 2'($urandom), int'($urandom % 4), "R4 random match");
        end

        // Directed regions: distinct, exact compare.
        for (int i = 0; i < N; i++) set_region(i, 16'hF000 + 16'(i), 16'h0, 1'b1, 9'h110);
        run_cycle(32'h5555_0000, 1'b1, 2'd2, 0, "R13");
        run_cycle(32'hF001_8000, 1'b0, 2'd2, 0, "R4 mask ignores low half");
        run_cycle(32'hF003_0000, 1'b1, 2'd2, 0, "R4 exact");

        // R5: region 3 and 5 overlap; lower wins.
        set_region(3, 16'h1234, 16'h0000, 1'b1, 9'h111);
        set_region(5, 16'h1200, 16'h00FF, 1'b1, 9'h110);
        chk(exp_sel(32'h1234_0000) == 3, "R5 model", 32'(exp_sel(32'h1234_0000)), 32'd3);
        run_cycle(32'h1234_0000, 1'b1, 2'd2, 0, "R5 priority");
        run_cycle(32'h1256_0000, 1'b1, 2'd2, 0, "R4 masked region 5");
        set_region(5, 16'h1200, 16'h00FF, 1'b0, 9'h110);
        run_cycle(32'h1256_0000, 1'b1, 2'd2, 0, "R4 invalid region");

        // R6: wait extremes. Region 1 16-bit 0 waits, region 2 8-bit 15 waits.
        set_region(1, 16'hA000, 16'h0, 1'b1, {1'b1, 1'b0, 2'b10, 1'b1, 4'd0});
        set_region(2, 16'hA100, 16'h0, 1'b1, {1'b1, 1'b0, 2'b01, 1'b1, 4'd15});
        for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++) begin
                run_cycle({16'hA000, 14'h0, 2'(o)}, 1'b0, 2'(s), 0, "R9 16-bit port");
                run_cycle({16'hA100, 14'h0, 2'(o)}, 1'b1, 2'(s), 0, "R9 8-bit port");
            end

        // R10: byte-write mode, 32-bit port.
        set_region(4, 16'hB000, 16'h0, 1'b1, {1'b0, 1'b0, 2'b00, 1'b1, 4'd1});
        run_cycle(32'hB000_0002, 1'b1, 2'd1, 0, "R10 read no strobes");
        run_cycle(32'hB000_0002, 1'b0, 2'd1, 0, "R10 write strobes");
        run_cycle(32'hB000_0003, 1'b0, 2'd0, 0, "R10 write byte");

        // R7: external termination.
        set_region(6, 16'hC000, 16'h0, 1'b1, {1'b1, 1'b0, 2'b00, 1'b0, 4'd0});
        run_cycle(32'hC000_0000, 1'b1, 2'd2, 3, "R7 external");
        run_cycle(32'hC000_0000, 1'b0, 2'd0, 0, "R7 external fast");

        // R11: clear region 6 valid mid-cycle.
        bus_start = 1'b1; bus_addr = 32'hC000_0000; bus_rd = 1'b1; bus_size = 2'd2;
        @(posedge clk); #1;
        bus_start = 1'b0;
        #2;
        chk(cs_n == 8'hBF, "R11 cycle started", {24'h0, cs_n}, 32'hBF);
        #4;
        @(posedge clk); #1;
        wr(6, 1, 32'h0000_0000);
        #2;
        chk(cs_n == 8'hBF, "R11 held after clear", {24'h0, cs_n}, 32'hBF);
        #4;
        ext_ack = 1'b1;
        @(posedge clk); #1;
        ext_ack = 1'b0;
        #2;
        chk(cs_n == 8'hFF, "R11 released", {24'h0, cs_n}, 32'hFF);
        #4;
        @(posedge clk); #1;
        run_cycle(32'hC000_0000, 1'b1, 2'd2, 0, "R11 next cycle");
        rd_chk(6, 1, "R12 valid cleared");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule